// File: doc/BRIEF.md
# Dual-Bank Sector Buffer Address Controller

This block drives the address and write-enable lines of a 16-bit input SRAM that holds the recent history of eight sampled channels. The memory is split into two equal banks, and each bank is cut into eight sectors, one sector per channel. One bank at a time takes writes. On every sample strobe the block issues eight back-to-back write cycles, one for each channel in channel order, all at the same offset inside their sectors. The offset moves on by one per sample period, so each sector behaves as a ring that always holds the newest 8k samples of its channel.

A trigger asks for the current history to be frozen. An accepted trigger is held until the next sample strobe. At that boundary the write side moves to the other bank, the offset of the last completed sample period is latched, and the frozen bank is handed to the read side. The read side then walks the frozen bank one whole sector at a time, channel 0 first. Each sector starts one past the latched offset, so the oldest sample comes out first. A downstream consumer advances the read address one word per request. A trigger that arrives while a readout is still running, or while a handover is already waiting, is dropped and raises a buffer-full flag.

Top module: `sect_buf_ctrl`

## Requirements
- R1: After reset, wr_en, rd_active and buf_full are 0, and the first writes go to bank 0.
- R2: Both addresses are laid out as bank in the MSB, then the sector (channel) number in the next SECT_W bits, then the offset in the low OFF_W bits.
- R3: A sample_tick seen while no write burst is running gives wr_en on the next eight clocks, for channels 0 to 7 in order, all at the same offset.
- R4: The write offset goes up by one after every burst and wraps from its top value (8191 by default) to 0. After reset the first burst uses offset 0.
- R5: A trigger accepted while idle does not move anything on its own. At the next sample_tick the write bank toggles before that tick's burst, so the whole burst goes to the new bank.
- R6: At the handover, rd_active rises on the old write bank at sector 0. The start offset is the last offset written before the handover, plus one, modulo the sector depth.
- R7: Each rd_req while rd_active moves the read offset up by one, circularly. After a full sector of words, the read moves to the next sector at the same start offset.
- R8: After the last word of sector 7 has been requested, rd_active falls. An rd_req while rd_active is 0 leaves rd_addr unchanged.
- R9: A trigger while a readout is active, or while a handover is pending, leaves the write bank unchanged and sets buf_full one clock later. buf_full stays set until the readout completes.
- R10: While writes and a readout overlap, the write bank and the read bank always differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_tick | input | 1 | One-clock strobe at the start of each sample period |
| trig_in | input | 1 | One-clock trigger request |
| rd_req | input | 1 | Consumer takes the current read word |
| wr_en | output | 1 | SRAM write cycle this clock |
| wr_addr | output | 1+SECT_W+OFF_W | Write address {bank, sector, offset} |
| rd_active | output | 1 | A readout of the frozen bank is in progress |
| rd_addr | output | 1+SECT_W+OFF_W | Read address {bank, sector, offset} |
| buf_full | output | 1 | A trigger was dropped, and the readout has not finished |

## Verification
A bad channel counter or offset register shows up on wr_addr within one clock of the first burst after the fault, because the eight words of a burst must share one offset and step through the sectors in order. A bank flag that toggles at the wrong moment puts the write bank equal to the read bank on the first overlapping write. A stale latched offset shows as a wrong start address the clock after the handover. A mistake in the read sector or word count appears at the ports only at the sector boundary or at the end of the readout, so the readout is run through a whole bank with wrap-around inside each sector, and rd_active must fall on exactly the last request.

// File: rtl/sbc_pkg.sv
// Shared types for the sector buffer controller.
// Assumes: nothing beyond the parameters given to each module.
package sbc_pkg;

    // Write-side sequencer states
    typedef enum logic [0:0] {
        WR_IDLE  = 1'b0,
        WR_BURST = 1'b1
    } wr_state_t;

endpackage

// File: rtl/sbc_wr_gen.sv
// Write address generator. One start pulse gives one burst of N_SECT write
// cycles, channels in ascending order, all at a single ring offset. The
// offset advances once per burst and wraps at the sector depth.
// Assumes: start is only raised while busy is low.
module sbc_wr_gen
    import sbc_pkg::*;
#(
    parameter int OFF_W  = 13,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic [SECT_W-1:0] ch,
    output logic [OFF_W-1:0]  off,
    output logic [OFF_W-1:0]  last_off
);
    localparam logic [SECT_W-1:0] LAST_CH = '1;

    wr_state_t state;

    assign busy = (state == WR_BURST);

    // Step through channels and advance the ring offset at the end of a burst
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= WR_IDLE;
            ch       <= '0;
            off      <= '0;
            last_off <= '1;
        end else begin
            case (state)
                WR_IDLE: begin
                    if (start) begin
                        state <= WR_BURST;
                        ch    <= '0;
                    end
                end
                default: begin
                    if (ch == LAST_CH) begin
                        state    <= WR_IDLE;
                        last_off <= off;
                        off      <= off + 1'b1;
                    end else begin
                        ch <= ch + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/sbc_rd_gen.sv
// Read address generator. On start it walks one bank sector by sector. Each
// sector covers a full ring of 2**OFF_W words starting at start_off, one word
// per step.
// Assumes: start is only raised while active is low.
module sbc_rd_gen #(
    parameter int OFF_W  = 13,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OFF_W-1:0]  start_off,
    input  logic              bank_in,
    input  logic              step,
    output logic              active,
    output logic              done,
    output logic              bank,
    output logic [SECT_W-1:0] sect,
    output logic [OFF_W-1:0]  off
);
    localparam logic [SECT_W-1:0] LAST_SECT = '1;
    localparam logic [OFF_W-1:0]  LAST_WORD = '1;

    logic [OFF_W-1:0] cnt;
    logic             sect_end;

    // Detect the last word of a sector and of the whole bank
    always_comb begin
        sect_end = active && step && (cnt == LAST_WORD);
        done     = sect_end && (sect == LAST_SECT);
    end

    // Load on start, then advance one word per accepted step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            bank   <= 1'b1;
            sect   <= '0;
            off    <= '0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            bank   <= bank_in;
            sect   <= '0;
            off    <= start_off;
            cnt    <= '0;
        end else if (active && step) begin
            off <= off + 1'b1;
            cnt <= cnt + 1'b1;
            if (sect_end) begin
                if (sect == LAST_SECT) begin
                    active <= 1'b0;
                end else begin
                    sect <= sect + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sbc_swap_ctrl.sv
// Bank handover control. A trigger is accepted only when no readout is
// running and no handover is waiting. It is then held until the next burst
// start, where the write bank flips. Rejected triggers set a full flag that
// clears when the readout completes.
// Assumes: burst_start is one clock wide.
module sbc_swap_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic burst_start,
    input  logic rd_active,
    input  logic rd_done,
    output logic swap,
    output logic wr_bank,
    output logic full
);
    logic pend;
    logic rd_busy;
    logic accept;
    logic reject;

    // Decide accept, reject and swap this cycle
    always_comb begin
        rd_busy = rd_active && !rd_done;
        accept  = trig && !pend && !rd_busy;
        reject  = trig && !accept;
        swap    = burst_start && pend;
    end

    // Hold a pending handover, flip the bank, track the full flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            wr_bank <= 1'b0;
            full    <= 1'b0;
        end else begin
            if (swap) begin
                pend    <= 1'b0;
                wr_bank <= ~wr_bank;
            end else if (accept) begin
                pend <= 1'b1;
            end
            if (reject) begin
                full <= 1'b1;
            end else if (rd_done) begin
                full <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sect_buf_ctrl.sv
// Dual-bank sector buffer controller top. One bank takes interleaved channel
// writes into per-channel rings while the other bank is read out sector by
// sector, starting just after the offset latched at the handover.
// Assumes: sample_tick is spaced at least N_SECT+1 clocks apart.
module sect_buf_ctrl #(
    parameter int OFF_W  = 13,
    parameter int SECT_W = 3,
    localparam int ADDR_W = 1 + SECT_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic              trig_in,
    input  logic              rd_req,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              rd_active,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              buf_full
);
    logic              burst_busy;
    logic              burst_start;
    logic [SECT_W-1:0] wr_ch;
    logic [OFF_W-1:0]  wr_off;
    logic [OFF_W-1:0]  wr_last;
    logic              wr_bank;
    logic              swap;
    logic              rd_done;
    logic              rd_bank;
    logic [SECT_W-1:0] rd_sect;
    logic [OFF_W-1:0]  rd_off;

    // A tick only starts a burst when the previous one has ended
    assign burst_start = sample_tick && !burst_busy;

    sbc_wr_gen #(.OFF_W(OFF_W), .SECT_W(SECT_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (burst_start),
        .busy     (burst_busy),
        .ch       (wr_ch),
        .off      (wr_off),
        .last_off (wr_last)
    );

    sbc_swap_ctrl u_swap (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig        (trig_in),
        .burst_start (burst_start),
        .rd_active   (rd_active),
        .rd_done     (rd_done),
        .swap        (swap),
        .wr_bank     (wr_bank),
        .full        (buf_full)
    );

    sbc_rd_gen #(.OFF_W(OFF_W), .SECT_W(SECT_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (swap),
        .start_off (wr_last + 1'b1),
        .bank_in   (wr_bank),
        .step      (rd_req),
        .active    (rd_active),
        .done      (rd_done),
        .bank      (rd_bank),
        .sect      (rd_sect),
        .off       (rd_off)
    );

    // Assemble SRAM addresses from bank, sector and offset
    always_comb begin
        wr_en   = burst_busy;
        wr_addr = {wr_bank, wr_ch, wr_off};
        rd_addr = {rd_bank, rd_sect, rd_off};
    end

endmodule

// File: rtl/sbc_checker.sv
// Port-level properties of the sector buffer controller, bound to the top.
module sbc_checker #(
    parameter int OFF_W  = 13,
    parameter int SECT_W = 3,
    localparam int ADDR_W = 1 + SECT_W + OFF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig_in,
    input logic              rd_req,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              rd_active,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              buf_full
);
    localparam logic [SECT_W-1:0] LAST_CH = '1;

    logic              wb, rb;
    logic [SECT_W-1:0] wsect;
    logic [OFF_W-1:0]  woff, roff;

    always_comb begin
        wb    = wr_addr[ADDR_W-1];
        wsect = wr_addr[OFF_W +: SECT_W];
        woff  = wr_addr[OFF_W-1:0];
        rb    = rd_addr[ADDR_W-1];
        roff  = rd_addr[OFF_W-1:0];
    end

    // R3
    burst_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wsect != LAST_CH) |=>
            (wr_en && wsect == $past(wsect) + 1'b1 && woff == $past(woff)));

    // R10
    bank_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_active) |-> (wb != rb));

    // R7
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && rd_req) |=> (roff == $past(roff) + 1'b1));

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_active) |=> ($stable(rd_addr) || rd_active));

    // R9
    full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_in && rd_active && !rd_req) |=> buf_full);

    // R9
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && rd_active) |=> (buf_full || !rd_active));

endmodule

bind sect_buf_ctrl sbc_checker #(.OFF_W(OFF_W), .SECT_W(SECT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_in   (trig_in),
    .rd_req    (rd_req),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .rd_active (rd_active),
    .rd_addr   (rd_addr),
    .buf_full  (buf_full)
);

// File: tb/sim_sect_buf_ctrl.sv
// Directed bench for the sector buffer controller, with a reduced sector depth.
module sim_sect_buf_ctrl;
    localparam int OFF_W  = 4;
    localparam int SECT_W = 3;
    localparam int ADDR_W = 1 + SECT_W + OFF_W;
    localparam int DEPTH  = 1 << OFF_W;
    localparam int NSECT  = 1 << SECT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_tick = 1'b0;
    logic              trig_in = 1'b0;
    logic              rd_req = 1'b0;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic              rd_active;
    logic [ADDR_W-1:0] rd_addr;
    logic              buf_full;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int e_bank = 0;
    int e_off  = 0;
    int e_last = DEPTH - 1;

    always #4 clk = ~clk;

    sect_buf_ctrl #(.OFF_W(OFF_W), .SECT_W(SECT_W)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (sample_tick),
        .trig_in     (trig_in),
        .rd_req      (rd_req),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .rd_active   (rd_active),
        .rd_addr     (rd_addr),
        .buf_full    (buf_full)
    );

    function automatic int mk_addr(input int b, input int s, input int o);
        return (b << (SECT_W + OFF_W)) | (s << OFF_W) | (o % DEPTH);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One sample period: eight channel writes in order, then idle
    task automatic run_period();
        @(negedge clk) sample_tick = 1'b1;
        @(negedge clk) sample_tick = 1'b0;
        for (int c = 0; c < NSECT; c++) begin
            chk("R3 wr_en in burst", int'(wr_en), 1);
            chk("R2/R4 wr_addr", int'(wr_addr), mk_addr(e_bank, c, e_off));
            @(negedge clk);
        end
        chk("R3 wr_en after burst", int'(wr_en), 0);
        e_last = e_off;
        e_off  = (e_off + 1) % DEPTH;
    endtask

    task automatic pulse_trig();
        @(negedge clk) trig_in = 1'b1;
        @(negedge clk) trig_in = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 wr_en", int'(wr_en), 0);
        chk("R1 rd_active", int'(rd_active), 0);
        chk("R1 buf_full", int'(buf_full), 0);
    endtask

    // Many periods so the offset wraps
    task automatic t_write_wrap();
        for (int p = 0; p < DEPTH + 2; p++) run_period();
        chk("R4 offset after wrap", e_off, 2);
    endtask

    // Trigger held until the next tick, then bank flips and readout starts
    task automatic t_handover(input int new_bank);
        int start;
        start = (e_last + 1) % DEPTH;
        pulse_trig();
        chk("R5 no early readout", int'(rd_active), 0);
        chk("R5 no write yet", int'(wr_en), 0);
        e_bank = new_bank;
        @(negedge clk) sample_tick = 1'b1;
        @(negedge clk) sample_tick = 1'b0;
        chk("R6 rd_active", int'(rd_active), 1);
        chk("R6 rd_addr start", int'(rd_addr), mk_addr(1 - new_bank, 0, start));
        chk("R5 first write in new bank", int'(wr_addr), mk_addr(new_bank, 0, e_off));
        repeat (NSECT) @(negedge clk);
        e_last = e_off;
        e_off  = (e_off + 1) % DEPTH;
    endtask

    // Trigger during readout is dropped
    task automatic t_reject();
        pulse_trig();
        chk("R9 buf_full set", int'(buf_full), 1);
        run_period();
        chk("R9 buf_full held", int'(buf_full), 1);
    endtask

    // Drain the whole bank and check every address
    task automatic t_readout(input int rbank, input int start);
        int hold;
        for (int s = 0; s < NSECT; s++) begin
            for (int i = 0; i < DEPTH; i++) begin
                chk("R7 rd_addr", int'(rd_addr), mk_addr(rbank, s, start + i));
                @(negedge clk) rd_req = 1'b1;
                @(negedge clk) rd_req = 1'b0;
            end
        end
        chk("R8 rd_active falls", int'(rd_active), 0);
        chk("R9 buf_full cleared", int'(buf_full), 0);
        hold = int'(rd_addr);
        @(negedge clk) rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
        chk("R8 rd_req ignored", int'(rd_addr), hold);
    endtask

    initial begin
        t_reset();
        t_write_wrap();
        t_handover(1);
        t_reject();
        t_readout(0, 2);
        t_handover(0);
        chk("R10 read bank after second swap", int'(rd_addr[ADDR_W-1]), 1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule